// File: doc/BRIEF.md
# Streaming CRC-8 Accumulator for Serial-Bus Identifiers

This block keeps a running 8-bit cyclic check over a stream of bytes. Each byte is presented with a valid strobe, and the block folds it into a registered remainder. It accepts one byte every clock, including on consecutive cycles. The check uses the generator x^8 + x^5 + x^4 + 1 in reflected (LSB-first) form, starts from a zero remainder and processes each byte least significant bit first. This is the check that protects 64-bit device identifiers and scratchpad reads on single-wire sensor buses.

A synchronous clear starts a new message. The current remainder is always visible, together with a registered flag that is high when the remainder is zero. A message that ends with its own correct check byte leaves a zero remainder, so the flag gives the pass indication one cycle after the last byte. The block does not frame messages or count their length. The byte update is built as an unrolled chain of single-bit shift steps rather than a stored table.

Top module: `crc8_stream_acc`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rem_o` is 0x00 and `zero_o` is 1.
- R2: When `clr_i` is high at a clock edge, `rem_o` is 0x00 after that edge, even if `vld_i` is high in the same cycle. The byte offered in that cycle is discarded.
- R3: When `vld_i` is high and `clr_i` is low at an edge, the new `rem_o` is T[old `rem_o` XOR `byte_i`]. T[i] is found by shifting i right 8 times, XORing 0x8C after any shift that drops out a 1. For example, T[0]=0x00, T[1]=0x5E, T[2]=0xBC, T[3]=0xE2, T[128]=0x8C and T[255]=0x35.
- R4: When `vld_i` and `clr_i` are both low at an edge, `rem_o` and `zero_o` keep their values.
- R5: Bytes are folded in the order they arrive, first byte first. For the same bytes, a different order in general gives a different remainder.
- R6: `zero_o` is 1 exactly when `rem_o` is 0x00. Both are registered and change at the same edge, one cycle after the byte that causes the change.
- R7: After a clear, a message followed by its own check byte (the remainder reached over the message) leaves `rem_o` at 0x00 and `zero_o` at 1. A message with one corrupted byte leaves `zero_o` at 0.
- R8: Bytes with `vld_i` high on consecutive cycles are each folded in, one per clock, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Restart: load the zero seed; has priority over a byte |
| vld_i | input | 1 | `byte_i` holds a byte to fold in this cycle |
| byte_i | input | 8 | Message byte, bit 0 processed first |
| rem_o | output | 8 | Registered running remainder |
| zero_o | output | 1 | Registered flag: remainder equals zero |

## Verification
The in-RTL assertions check four properties on every cycle. A clear yields zero and wins over a byte. An idle cycle holds both registers. The flag always agrees with the remainder. A byte equal to the current remainder drives it to zero, because T[0] is zero. The exact polynomial arithmetic can only be shown by the bench's scenarios. These include every single-byte value, back-to-back byte pairs from all 256 starting bytes, order sensitivity, and complete identifiers that end in correct or corrupted check bytes.

// File: rtl/crc8_acc_pkg.sv
package crc8_acc_pkg;

    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_CRC_W  = 8;
    // reflected form of x^8 + x^5 + x^4 + 1
    localparam logic [7:0]  DEF_POLY   = 8'h8C;
    localparam logic [7:0]  DEF_SEED   = 8'h00;

endpackage

// File: rtl/crc8_lfsr_step.sv
// One LSB-first shift of the check register with one incoming data bit.
module crc8_lfsr_step #(
    parameter int unsigned          CRC_W = 8,
    parameter logic [CRC_W-1:0]     POLY  = 8'h8C
) (
    input  logic [CRC_W-1:0] crc_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);
    logic             fb;
    logic [CRC_W-1:0] shifted;

    always_comb begin
        fb      = crc_i[0] ^ bit_i;
        shifted = crc_i >> 1;
        crc_o   = fb ? (shifted ^ POLY) : shifted;
    end
endmodule

// File: rtl/crc8_byte_engine.sv
// Unrolled byte update: a chain of DATA_W single-bit steps, bit 0 first.
module crc8_byte_engine #(
    parameter int unsigned          DATA_W = 8,
    parameter int unsigned          CRC_W  = 8,
    parameter logic [CRC_W-1:0]     POLY   = 8'h8C
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [CRC_W-1:0] stage [DATA_W+1];

    assign stage[0] = crc_i;

    for (genvar k = 0; k < DATA_W; k++) begin : g_step
        crc8_lfsr_step #(
            .CRC_W (CRC_W),
            .POLY  (POLY)
        ) u_step (
            .crc_i (stage[k]),
            .bit_i (data_i[k]),
            .crc_o (stage[k+1])
        );
    end

    assign crc_o = stage[DATA_W];
endmodule

// File: rtl/crc8_stream_acc.sv
module crc8_stream_acc
    import crc8_acc_pkg::*;
#(
    parameter int unsigned          DATA_W = DEF_DATA_W,
    parameter int unsigned          CRC_W  = DEF_CRC_W,
    parameter logic [CRC_W-1:0]     POLY   = DEF_POLY,
    parameter logic [CRC_W-1:0]     SEED   = DEF_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic [CRC_W-1:0]  rem_o,
    output logic              zero_o
);
    localparam logic [CRC_W-1:0] ZERO_REM = '0;

    typedef struct packed {
        logic [CRC_W-1:0] rem;
        logic             zero;
    } acc_state_t;

    acc_state_t       st_d, st_q;
    logic [CRC_W-1:0] upd_rem;

    crc8_byte_engine #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (POLY)
    ) u_engine (
        .crc_i  (st_q.rem),
        .data_i (byte_i),
        .crc_o  (upd_rem)
    );

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.rem = SEED;
        end else if (vld_i) begin
            st_d.rem = upd_rem;
        end
        st_d.zero = (st_d.rem == ZERO_REM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rem  <= SEED;
            st_q.zero <= (SEED == ZERO_REM);
        end else begin
            st_q <= st_d;
        end
    end

    assign rem_o  = st_q.rem;
    assign zero_o = st_q.zero;

    AST_RESET_SEED: assert property (@(posedge clk)
        !rst_n |=> (rem_o == SEED)); // R1

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (rem_o == SEED)); // R2

    AST_MATCH_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !clr_i && (byte_i == rem_o)) |=> (rem_o == ZERO_REM)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i && !clr_i) |=> ($stable(rem_o) && $stable(zero_o))); // R4

    AST_FLAG_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == (rem_o == ZERO_REM)); // R6
endmodule

// File: tb/tb_crc8_stream_acc.sv
`timescale 1ns/1ps
module tb_crc8_stream_acc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_i = 1'b0;
    logic       vld_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic [7:0] rem_o;
    logic       zero_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    crc8_stream_acc dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_i),
        .vld_i  (vld_i),
        .byte_i (byte_i),
        .rem_o  (rem_o),
        .zero_o (zero_o)
    );

    function automatic logic [7:0] ref_upd(input logic [7:0] old, input logic [7:0] b);
        logic [7:0] c;
        c = old ^ b;
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
        end
        return c;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // drive at falling edge, step one rising edge, leave sampling time afterwards
    task automatic cyc(input logic c, input logic v, input logic [7:0] b);
        @(negedge clk);
        clr_i  = c;
        vld_i  = v;
        byte_i = b;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 8'hA5);
    endtask

    initial begin
        logic [7:0] e;
        logic [7:0] held;
        logic [7:0] id [8];

        // R1: reset state
        @(posedge clk);
        #1;
        check8("R1 rem during reset", rem_o, 8'h00);
        check1("R1 zero during reset", zero_o, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        check8("R1 rem after reset", rem_o, 8'h00);
        check1("R1 zero after reset", zero_o, 1'b1);

        // R3: listed table entries
        cyc(1'b1, 1'b0, 8'h00); cyc(1'b0, 1'b1, 8'h01); check8("R3 T[1]", rem_o, 8'h5E);
        cyc(1'b1, 1'b0, 8'h00); cyc(1'b0, 1'b1, 8'h02); check8("R3 T[2]", rem_o, 8'hBC);
        cyc(1'b1, 1'b0, 8'h00); cyc(1'b0, 1'b1, 8'h03); check8("R3 T[3]", rem_o, 8'hE2);
        cyc(1'b1, 1'b0, 8'h00); cyc(1'b0, 1'b1, 8'h80); check8("R3 T[128]", rem_o, 8'h8C);
        cyc(1'b1, 1'b0, 8'h00); cyc(1'b0, 1'b1, 8'hFF); check8("R3 T[255]", rem_o, 8'h35);

        // R3 / R6: every single-byte value from the zero seed
        for (int i = 0; i < 256; i++) begin
            cyc(1'b1, 1'b0, 8'h00);
            cyc(1'b0, 1'b1, i[7:0]);
            e = ref_upd(8'h00, i[7:0]);
            check8("R3 single byte", rem_o, e);
            check1("R6 flag single byte", zero_o, (e == 8'h00));
        end

        // R8 / R3: back-to-back pairs from every first byte (nonzero prior state)
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b2;
            b2 = 8'(i * 37 + 11);
            cyc(1'b1, 1'b0, 8'h00);
            cyc(1'b0, 1'b1, i[7:0]);
            cyc(1'b0, 1'b1, b2);
            e = ref_upd(ref_upd(8'h00, i[7:0]), b2);
            check8("R8 back-to-back pair", rem_o, e);
            check1("R6 flag pair", zero_o, (e == 8'h00));
        end

        // R5: order matters, first byte first
        cyc(1'b1, 1'b0, 8'h00); cyc(1'b0, 1'b1, 8'h01); cyc(1'b0, 1'b1, 8'h02);
        check8("R5 order 01,02", rem_o, ref_upd(ref_upd(8'h00, 8'h01), 8'h02));
        cyc(1'b1, 1'b0, 8'h00); cyc(1'b0, 1'b1, 8'h02); cyc(1'b0, 1'b1, 8'h01);
        check8("R5 order 02,01", rem_o, ref_upd(ref_upd(8'h00, 8'h02), 8'h01));

        // R4: idle holds the remainder over several cycles
        cyc(1'b1, 1'b0, 8'h00); cyc(1'b0, 1'b1, 8'h3C);
        held = ref_upd(8'h00, 8'h3C);
        for (int k = 0; k < 4; k++) begin
            idle();
            check8("R4 idle hold", rem_o, held);
            check1("R4 idle flag hold", zero_o, 1'b0);
        end

        // R2: clear beats a simultaneous byte
        cyc(1'b1, 1'b1, 8'h55);
        check8("R2 clear priority", rem_o, 8'h00);
        check1("R2 clear flag", zero_o, 1'b1);

        // R7: 8-byte identifier ending in its own check byte
        id[0] = 8'h28; id[1] = 8'hFF; id[2] = 8'h4C; id[3] = 8'h1A;
        id[4] = 8'h93; id[5] = 8'h16; id[6] = 8'h04;
        e = 8'h00;
        for (int k = 0; k < 7; k++) e = ref_upd(e, id[k]);
        id[7] = e;
        cyc(1'b1, 1'b0, 8'h00);
        for (int k = 0; k < 8; k++) cyc(1'b0, 1'b1, id[k]);
        check8("R7 good id remainder", rem_o, 8'h00);
        check1("R7 good id flag", zero_o, 1'b1);

        // R7: same identifier with one corrupted byte
        cyc(1'b1, 1'b0, 8'h00);
        for (int k = 0; k < 8; k++) cyc(1'b0, 1'b1, (k == 3) ? (id[k] ^ 8'h10) : id[k]);
        check1("R7 corrupted id flag", zero_o, 1'b0);

        done = 1'b1;
    end

    initial begin
        int cycles;
        cycles = 0;
        while (!done && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all R) actual=timeout expected=completion");
        end
        #3;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule